// File: doc/BRIEF.md
# Burst Address Control Unit

This unit sits in front of a pipelined burst memory array and decides, on every rising clock edge, which word the array should access next. A burst opens when one of two start strobes is accepted. The first start strobe comes from the processor and the second from the cache controller. When a burst opens, the unit captures the external address. After that, an active-low advance strobe either steps the two lowest address bits to the next beat of a four-beat burst or holds them, which suspends the burst.

A static order pin chooses how the low bits are stepped. In linear order they count up modulo four from the start value. In interleaved order they are the start value XORed with the beat number. The unit also reports whether an access is valid and whether it is a read or a write, taken from an active-low write qualifier. Three chip selects gate acceptance. The memory array and the data path are outside this unit.

Top module: `burst_addr_ctrl`

## Requirements
- R1: A processor start (strb_proc_n low with cs_pri_n low) with the part selected (cs_hi high, cs_lo_n low) makes the next cycle a valid read at exactly addr_in.
- R2: On an accepted processor start, wr_n and adv_n have no effect: the access is a read at beat 0, even with wr_n low and adv_n low.
- R3: With cs_pri_n high, strb_proc_n low is not a start. If strb_ctrl_n is high on that edge, a running burst continues as if no strobe were active.
- R4: A controller start (strb_ctrl_n low) is accepted only on an edge where no processor start is accepted. The access type is taken from wr_n on that same edge: low means write (acc_write=1), high means read.
- R5: On an edge where a start strobe is accepted but the part is not fully selected (cs_pri_n high, cs_hi low, or cs_lo_n high), the burst ends and acc_valid drops on the next cycle.
- R6: During a burst with no start strobe, adv_n low moves to the next beat and adv_n high keeps the current beat. In both cases acc_write follows the inverse of wr_n sampled on that edge.
- R7: With order_il low, the low two address bits on beat k are (start + k) mod 4.
- R8: With order_il high, the low two address bits on beat k are start XOR k.
- R9: After four advances the low bits return to the start value, and the upper address bits keep the captured value for the whole burst.
- R10: Until the first accepted start after reset, edges without a start give acc_valid low.
- R11: Reset drives acc_valid, acc_write and acc_addr to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_pri_n | input | 1 | Primary chip select, active low; high blocks the processor start |
| cs_hi | input | 1 | Chip select, active high |
| cs_lo_n | input | 1 | Chip select, active low |
| strb_proc_n | input | 1 | Processor start strobe, active low |
| strb_ctrl_n | input | 1 | Controller start strobe, active low |
| adv_n | input | 1 | Advance strobe, active low |
| wr_n | input | 1 | Write qualifier, low means write |
| order_il | input | 1 | Static burst order: 0 linear, 1 interleaved |
| addr_in | input | ADDR_W | External start address |
| acc_addr | output | ADDR_W | Address for the current access |
| acc_valid | output | 1 | Current access is valid |
| acc_write | output | 1 | Current access is a write |

## Verification
Every result is registered once. The address, valid flag and type sampled at one rising edge therefore appear at the ports one edge later and stay there for a full cycle. The bench changes inputs just after a falling edge and reads outputs at the following falling edge, which is half a cycle after the edge that produced them. At that point it compares the ports against a beat-by-beat expectation built from the rules above. The exception is acc_addr in interleaved mode, which also depends on the static order pin, so it is compared only when the mode is held constant across the burst.

// File: rtl/bac_pkg.sv
package bac_pkg;

  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_LOAD  = 2'd1,
    EV_DESEL = 2'd2
  } start_ev_t;

endpackage

// File: rtl/bac_start_decode.sv
module bac_start_decode
  import bac_pkg::*;
(
  input  logic      cs_pri_n,
  input  logic      cs_hi,
  input  logic      cs_lo_n,
  input  logic      strb_proc_n,
  input  logic      strb_ctrl_n,
  input  logic      wr_n,
  output start_ev_t ev,
  output logic      ld_write
);

  logic proc_go;
  logic ctrl_go;
  logic chip_sel;

  always_comb begin
    proc_go  = !strb_proc_n && !cs_pri_n;
    ctrl_go  = !strb_ctrl_n && !proc_go;
    chip_sel = !cs_pri_n && cs_hi && !cs_lo_n;
    ev       = EV_NONE;
    if (proc_go || ctrl_go) begin
      ev = chip_sel ? EV_LOAD : EV_DESEL;
    end
    // processor starts are always reads; controller starts take wr_n now
    ld_write = ctrl_go && !wr_n;
  end

endmodule

// File: rtl/bac_beat_counter.sv
module bac_beat_counter #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              step,
  output logic [BEAT_W-1:0] idx_q
);

  logic [BEAT_W-1:0] idx_d;
  logic              idx_en;

  always_comb begin
    idx_en = clr || step;
    idx_d  = clr ? '0 : idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  p_clear_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (idx_q == '0));

  p_hold_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !step) |=> $stable(idx_q));

  p_next_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr) |=> (idx_q == BEAT_W'($past(idx_q) + 1'b1)));

endmodule

// File: rtl/bac_order_map.sv
module bac_order_map #(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] base_low,
  input  logic [BEAT_W-1:0] idx,
  input  logic              order_il,
  output logic [BEAT_W-1:0] low
);

  logic [BEAT_W-1:0] lin_low;
  logic [BEAT_W-1:0] il_low;

  generate
    for (genvar b = 0; b < BEAT_W; b++) begin : g_xor_bit
      assign il_low[b] = base_low[b] ^ idx[b];
    end
  endgenerate

  always_comb begin
    lin_low = base_low + idx;
    low     = order_il ? il_low : lin_low;
  end

  always_comb begin
    if (order_il) begin
      p_il_inverse_r8: assert ((low ^ base_low) == idx);
    end else begin
      p_lin_inverse_r7: assert (BEAT_W'(low - base_low) == idx);
    end
  end

endmodule

// File: rtl/burst_addr_ctrl.sv
module burst_addr_ctrl
  import bac_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_pri_n,
  input  logic              cs_hi,
  input  logic              cs_lo_n,
  input  logic              strb_proc_n,
  input  logic              strb_ctrl_n,
  input  logic              adv_n,
  input  logic              wr_n,
  input  logic              order_il,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              acc_valid,
  output logic              acc_write
);

  localparam int UP_W = ADDR_W - BEAT_W;

  start_ev_t         ev;
  logic              ld_write;
  logic [ADDR_W-1:0] base_q;
  logic              active_q;
  logic              active_d;
  logic              write_q;
  logic              write_d;
  logic              base_en;
  logic              beat_step;
  logic              beat_clr;
  logic [BEAT_W-1:0] idx_q;
  logic [BEAT_W-1:0] low_bits;

  bac_start_decode u_dec (
    .cs_pri_n    (cs_pri_n),
    .cs_hi       (cs_hi),
    .cs_lo_n     (cs_lo_n),
    .strb_proc_n (strb_proc_n),
    .strb_ctrl_n (strb_ctrl_n),
    .wr_n        (wr_n),
    .ev          (ev),
    .ld_write    (ld_write)
  );

  always_comb begin
    base_en   = (ev == EV_LOAD);
    beat_clr  = (ev == EV_LOAD);
    beat_step = (ev == EV_NONE) && active_q && !adv_n;
    unique case (ev)
      EV_LOAD: begin
        active_d = 1'b1;
        write_d  = ld_write;
      end
      EV_DESEL: begin
        active_d = 1'b0;
        write_d  = 1'b0;
      end
      default: begin
        active_d = active_q;
        write_d  = active_q && !wr_n;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (base_en) begin
      base_q <= addr_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      write_q  <= 1'b0;
    end else begin
      active_q <= active_d;
      write_q  <= write_d;
    end
  end

  bac_beat_counter #(.BEAT_W(BEAT_W)) u_beat (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (beat_clr),
    .step  (beat_step),
    .idx_q (idx_q)
  );

  bac_order_map #(.BEAT_W(BEAT_W)) u_map (
    .base_low (base_q[BEAT_W-1:0]),
    .idx      (idx_q),
    .order_il (order_il),
    .low      (low_bits)
  );

  assign acc_addr  = {base_q[ADDR_W-1:BEAT_W], low_bits};
  assign acc_valid = active_q;
  assign acc_write = write_q;

  p_proc_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb_proc_n && !cs_pri_n && cs_hi && !cs_lo_n)
      |=> (acc_valid && !acc_write && acc_addr == $past(addr_in)));

  p_ctrl_type_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_proc_n && !strb_ctrl_n && !cs_pri_n && cs_hi && !cs_lo_n)
      |=> (acc_write == !$past(wr_n)));

  p_deselect_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_DESEL) |=> !acc_valid);

  p_upper_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != EV_LOAD) |=> $stable(acc_addr[ADDR_W-1:BEAT_W]));

  p_idle_stays_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_valid && ev == EV_NONE) |=> !acc_valid);

  initial begin
    p_width_ok_r9: assert (UP_W > 0);
  end

endmodule

// File: tb/tb_burst_addr_ctrl.sv
`timescale 1ns/1ps
module tb_burst_addr_ctrl;

  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cs_pri_n, cs_hi, cs_lo_n;
  logic          strb_proc_n, strb_ctrl_n, adv_n, wr_n, order_il;
  logic [AW-1:0] addr_in;
  logic [AW-1:0] acc_addr;
  logic          acc_valid, acc_write;

  int total = 0;
  int bad   = 0;

  // expected state, from the requirements
  logic          e_act   = 1'b0;
  logic          e_wr    = 1'b0;
  logic [AW-1:0] e_base  = '0;
  logic [1:0]    e_k     = 2'd0;

  always #2 clk = ~clk;

  burst_addr_ctrl #(.ADDR_W(AW), .BEAT_W(2)) dut (
    .clk(clk), .rst_n(rst_n), .cs_pri_n(cs_pri_n), .cs_hi(cs_hi),
    .cs_lo_n(cs_lo_n), .strb_proc_n(strb_proc_n), .strb_ctrl_n(strb_ctrl_n),
    .adv_n(adv_n), .wr_n(wr_n), .order_il(order_il), .addr_in(addr_in),
    .acc_addr(acc_addr), .acc_valid(acc_valid), .acc_write(acc_write)
  );

  task automatic chk(input string req, input string what,
                     input logic [AW-1:0] got, input logic [AW-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%0h exp=%0h", req, what, got, exp);
    end
  endtask

  // one edge: drive after falling edge, sample at the next falling edge
  task automatic edge_step(input string req, input logic p_n, input logic c_n,
                           input logic adv, input logic w, input logic c1,
                           input logic c2, input logic c3,
                           input logic [AW-1:0] a);
    logic sel, pgo, cgo;
    logic [1:0] lo;
    strb_proc_n = p_n; strb_ctrl_n = c_n; adv_n = adv; wr_n = w;
    cs_pri_n = c1; cs_hi = c2; cs_lo_n = c3; addr_in = a;
    sel = !c1 && c2 && !c3;
    pgo = !p_n && !c1;
    cgo = !c_n && !pgo;
    if (pgo || cgo) begin
      if (sel) begin
        e_base = a; e_k = 2'd0; e_act = 1'b1; e_wr = cgo && !w;
      end else begin
        e_act = 1'b0; e_wr = 1'b0;
      end
    end else if (e_act) begin
      if (!adv) e_k = e_k + 2'd1;
      e_wr = !w;
    end else begin
      e_wr = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    lo = order_il ? (e_base[1:0] ^ e_k) : (e_base[1:0] + e_k);
    chk(req, "valid", AW'(acc_valid), AW'(e_act));
    if (e_act) begin
      chk(req, "write", AW'(acc_write), AW'(e_wr));
      chk(req, "addr", acc_addr, {e_base[AW-1:2], lo});
    end
  endtask

  initial begin
    #150000;
    bad++;
    $display("FAIL watchdog expired got=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cs_pri_n = 1'b1; cs_hi = 1'b0; cs_lo_n = 1'b1;
    strb_proc_n = 1'b1; strb_ctrl_n = 1'b1; adv_n = 1'b1; wr_n = 1'b1;
    order_il = 1'b0; addr_in = '0;
    repeat (3) @(negedge clk);
    // R11: reset values
    chk("R11", "valid", AW'(acc_valid), '0);
    chk("R11", "write", AW'(acc_write), '0);
    chk("R11", "addr", acc_addr, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: no start yet, advancing and suspending edges give no access
    edge_step("R10", 1, 1, 0, 0, 0, 1, 0, 18'h1234);
    edge_step("R10", 1, 1, 1, 1, 0, 1, 0, 18'h0);
    // R3: blocked processor strobe is not a start
    edge_step("R3", 0, 1, 0, 0, 1, 1, 0, 18'h3ff);

    // sweep both orders, all start values, both strobes, both write values
    for (int m = 0; m < 2; m++) begin
      order_il = m[0];
      for (int s = 0; s < 4; s++) begin
        for (int typ = 0; typ < 2; typ++) begin
          for (int w = 0; w < 2; w++) begin
            logic [AW-1:0] a;
            logic [6:0] pat;
            a = {16'(16'h5a3c + s * 16'h0111 + typ * 16'h2000 + w), s[1:0]};
            pat = 7'b1011101 ^ 7'(s * 3 + w);
            if (typ == 0)
              // R1, R2: processor start ignores wr_n low and adv_n low
              edge_step("R1_R2", 0, 1, 0, 0, 0, 1, 0, a);
            else
              edge_step("R4", 1, 0, 0, w[0], 0, 1, 0, a);
            for (int b = 0; b < 7; b++) begin
              edge_step(m == 0 ? "R7_R6_R9" : "R8_R6_R9",
                        1, 1, pat[b], w[0], 0, 1, 0, 18'h3ffff);
            end
          end
        end
      end
    end

    // R9: four straight advances wrap to start value
    order_il = 1'b0;
    edge_step("R1", 0, 1, 1, 1, 0, 1, 0, 18'h2a5e6);
    for (int b = 0; b < 4; b++) edge_step("R9", 1, 1, 0, 1, 0, 1, 0, 18'h0);
    chk("R9", "wrap_low", AW'(acc_addr[1:0]), AW'(2'b10));

    // R3: blocked processor strobe during a burst just continues
    edge_step("R3", 0, 1, 0, 1, 1, 1, 0, 18'h11111);
    // R4: both strobes low with part selected, processor wins, read
    edge_step("R4", 0, 0, 0, 0, 0, 1, 0, 18'h0beef);

    // R5: every not-fully-selected combination with a start strobe low
    for (int c = 0; c < 8; c++) begin
      if (c == 2) continue;
      edge_step("R5", 1, 0, 0, 0, 0, 1, 0, 18'h00c0d);
      edge_step("R5", c[2] ? 1 : 0, 0, 0, 0, c[2], c[1], c[0], 18'h3c0de);
      edge_step("R5", 1, 1, 0, 0, 0, 1, 0, 18'h0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule